// File: doc/BRIEF.md
# Phase-Accumulator NCO with Synchronized Frequency Load

This block is the phase accumulator of a numerically controlled oscillator that runs on the IF sample clock. Each enabled cycle the accumulator advances by an effective increment. That increment is the stored frequency word, plus or minus a signed correction from an external loop filter, plus an optional one-LSB test carry. The accumulator wraps modulo its width. The phase output feeds a sine lookup that lives outside this block.

A new frequency word comes in through a load request. The request is the logical OR of a pin and a register bit, and either source may be asynchronous to the clock. The OR is passed through a synchronizer, and its rising edge is detected. The word on the frequency input is then committed on the sixth clock edge after the request is first sampled high. While a load is in flight, a busy output is high and any further request edge is dropped.

Pulling the enable input low freezes the phase, clears the stored word and cancels a pending load. A fresh load is needed after re-enable.

Top module: `sync_load_nco`

## Requirements
- R1: After reset, phase is 0, busy is 0 and the stored frequency word is 0, so with zero correction and carry low the phase stays 0.
- R2: The load request is loadPin OR loadBit. With one source held low, a rising edge on the other starts a load. While one source is held high, pulses on the other start no load.
- R3: If the request is first sampled high at clock edge E0 after being sampled low at the edge before, the value on fcwIn at edge E6 becomes the stored word at E6. The phase first advances by that word at E7. Busy is 1 after edges E2 to E5 and 0 after E6.
- R4: A request edge whose edge E2 comes while busy is 1 is ignored. It neither restarts the count nor loads a word. A request whose E0 comes five or more edges after the previous accepted E0 is accepted.
- R5: The loop correction is loopVal (16-bit two's complement), sign-extended to 32 bits. When addLoop is 1 it is added to the increment; when addLoop is 0 it is subtracted.
- R6: When carryIn is 1, one extra LSB is added to the phase on every enabled cycle. When carryIn is 0, it adds nothing.
- R7: On each edge where enable is 0, the phase holds its value, the stored word becomes 0, a pending load is cancelled and busy is 0. After re-enable, the phase advances only by the correction and carry until a new load completes.
- R8: The phase accumulates modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | IF sample clock |
| rstN | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Oscillator enable; low freezes phase and clears the word |
| loadPin | input | 1 | External load request source |
| loadBit | input | 1 | Register load request source |
| fcwIn | input | 32 | Frequency word to load |
| loopVal | input | 16 | Signed loop-filter correction |
| addLoop | input | 1 | 1: add the correction, 0: subtract it |
| carryIn | input | 1 | Test carry, adds one LSB per cycle |
| busy | output | 1 | High while a load is in flight |
| phase | output | 32 | Accumulator phase |

## Verification
The bound checker checks the following on every cycle:
- the phase is frozen and busy is cleared on any edge with enable low;
- busy never rises out of a disabled cycle;
- an uninterrupted busy span always lasts exactly the commit hold.

Other behaviours depend on data values and on when requests arrive, so only the bench's scenarios show them:
- which word lands, and at which edge;
- that a request inside the lockout is dropped, while one at the boundary is taken;
- that the OR blocks edges while one source is held high;
- the sign of the correction, the test carry and the wrap.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef struct packed {
    logic run;
    logic commit;
    logic clear;
  } ncoStrobe_t;
endpackage

// File: rtl/nco_load_ctl.sv
module nco_load_ctl
  import nco_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOAD_LAT    = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       loadPin,
  input  logic       loadBit,
  output ncoStrobe_t strobe,
  output logic       busy
);
  localparam int HOLD  = LOAD_LAT - SYNC_STAGES;
  localparam int CNT_W = $clog2(HOLD + 1);

  logic [SYNC_STAGES:0] syncChain;
  logic [CNT_W-1:0]     holdCnt;
  logic                 loadReq;
  logic                 reqRise;

  assign loadReq = loadPin | loadBit;

  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-1:0], loadReq};
  end

  // edge seen between the last sync stage and the extra history stage
  assign reqRise = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rstN)               holdCnt <= '0;
    else if (!enable)        holdCnt <= '0;
    else if (holdCnt != '0)  holdCnt <= holdCnt - 1'b1;
    else if (reqRise)        holdCnt <= CNT_W'(HOLD);
  end

  assign busy          = (holdCnt != '0);
  assign strobe.run    = enable;
  assign strobe.clear  = ~enable;
  assign strobe.commit = enable && (holdCnt == CNT_W'(1));
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int LOOP_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ncoStrobe_t         strobe,
  input  logic [PHASE_W-1:0] fcwIn,
  input  logic [LOOP_W-1:0]  loopVal,
  input  logic               addLoop,
  input  logic               carryIn,
  output logic [PHASE_W-1:0] phase
);
  logic [PHASE_W-1:0] fcwReg;
  logic [PHASE_W-1:0] corrExt;
  logic [PHASE_W-1:0] corrSigned;
  logic [PHASE_W-1:0] stepVal;

  generate
    if (PHASE_W > LOOP_W) begin : g_ext
      assign corrExt = {{(PHASE_W-LOOP_W){loopVal[LOOP_W-1]}}, loopVal};
    end else begin : g_trunc
      assign corrExt = loopVal[PHASE_W-1:0];
    end
  endgenerate

  assign corrSigned = addLoop ? corrExt : ('0 - corrExt);
  assign stepVal    = fcwReg + corrSigned + {{(PHASE_W-1){1'b0}}, carryIn};

  always_ff @(posedge clk) begin
    if (!rstN)              fcwReg <= '0;
    else if (strobe.clear)  fcwReg <= '0;
    else if (strobe.commit) fcwReg <= fcwIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           phase <= '0;
    else if (strobe.run) phase <= phase + stepVal;
  end
endmodule

// File: rtl/sync_load_nco.sv
module sync_load_nco
  import nco_pkg::*;
#(
  parameter int PHASE_W     = 32,
  parameter int LOOP_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int LOAD_LAT    = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               loadPin,
  input  logic               loadBit,
  input  logic [PHASE_W-1:0] fcwIn,
  input  logic [LOOP_W-1:0]  loopVal,
  input  logic               addLoop,
  input  logic               carryIn,
  output logic               busy,
  output logic [PHASE_W-1:0] phase
);
  ncoStrobe_t strobe;

  nco_load_ctl #(.SYNC_STAGES(SYNC_STAGES), .LOAD_LAT(LOAD_LAT)) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .loadPin(loadPin),
    .loadBit(loadBit), .strobe(strobe), .busy(busy)
  );

  nco_datapath #(.PHASE_W(PHASE_W), .LOOP_W(LOOP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fcwIn(fcwIn),
    .loopVal(loopVal), .addLoop(addLoop), .carryIn(carryIn), .phase(phase)
  );
endmodule

// File: rtl/sync_load_nco_chk.sv
module sync_load_nco_chk #(
  parameter int PHASE_W     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LOAD_LAT    = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               busy,
  input logic [PHASE_W-1:0] phase
);
  localparam int HOLD = LOAD_LAT - SYNC_STAGES;

  int runLen;
  always_ff @(posedge clk) begin
    if (!rstN)     runLen <= 0;
    else if (busy) runLen <= runLen + 1;
    else           runLen <= 0;
  end

  // R7
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> phase == $past(phase));

  // R7
  busy_off_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busy);

  // R7
  busy_rise_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(enable));

  // R3
  busy_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(enable)) |-> runLen == HOLD);
endmodule

bind sync_load_nco sync_load_nco_chk #(
  .PHASE_W(PHASE_W), .SYNC_STAGES(SYNC_STAGES), .LOAD_LAT(LOAD_LAT)
) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .busy(busy), .phase(phase)
);

// File: tb/sim_sync_load_nco.sv
`timescale 1ns/1ps
module sim_sync_load_nco;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b1;
  logic        loadPin = 1'b0;
  logic        loadBit = 1'b0;
  logic [31:0] fcwIn = '0;
  logic [15:0] loopVal = '0;
  logic        addLoop = 1'b1;
  logic        carryIn = 1'b0;
  logic        busy;
  logic [31:0] phase;

  always #2 clk = ~clk;

  sync_load_nco u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .loadPin(loadPin),
    .loadBit(loadBit), .fcwIn(fcwIn), .loopVal(loopVal), .addLoop(addLoop),
    .carryIn(carryIn), .busy(busy), .phase(phase)
  );

  typedef struct {
    logic [31:0] ph;
    logic        bz;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  int total = 0;
  int fails = 0;
  bit done = 0;

  // requirement-level model state
  logic [31:0] mPhase = '0;
  logic [31:0] mFcw = '0;
  int          mHold = 0;
  bit          h1 = 0, h2 = 0, h3 = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge with inputs set; predicts the next edge
  task automatic tick(input string tag);
    exp_t e;
    logic [31:0] corr;
    bit reqNow, rise, commitNow;
    reqNow    = loadPin | loadBit;
    rise      = h2 && !h3;
    corr      = {{16{loopVal[15]}}, loopVal};
    if (!addLoop) corr = 32'd0 - corr;
    commitNow = enable && (mHold == 1);
    if (enable) mPhase = mPhase + mFcw + corr + {31'd0, carryIn};
    if (!enable)        mFcw = '0;
    else if (commitNow) mFcw = fcwIn;
    if (!enable)        mHold = 0;
    else if (mHold != 0) mHold = mHold - 1;
    else if (rise)      mHold = 4;
    h3 = h2; h2 = h1; h1 = reqNow;
    e.ph = mPhase; e.bz = (mHold != 0); e.tag = tag;
    expQ.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  // monitor: compares each result just after the edge that produced it
  always @(posedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      #1;
      check({e.tag, " phase"}, phase, e.ph);
      check({e.tag, " busy"}, {31'd0, busy}, {31'd0, e.bz});
    end
  end

  initial begin
    #200000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset phase", phase, 32'd0);
    check("R1 reset busy", {31'd0, busy}, 32'd0);
    run(4, "R1 idle");

    // R2 R3: pin edge with bit low
    fcwIn = 32'h0000_1000; loadPin = 1'b1;
    tick("R3 pin load E0");
    fcwIn = 32'h0000_2000;
    run(4, "R3 pin load window");
    loadPin = 1'b0;
    run(6, "R3 pin load run");

    // R2: bit edge with pin low
    fcwIn = 32'h0300_0000; loadBit = 1'b1;
    run(3, "R2 bit load");
    loadBit = 1'b0;
    run(8, "R2 bit load run");

    // R2: pin held high blocks bit pulses
    loadPin = 1'b1; fcwIn = 32'h0000_0777;
    run(10, "R2 pin high load");
    fcwIn = 32'h0055_0000;
    loadBit = 1'b1; run(2, "R2 blocked pulse");
    loadBit = 1'b0; run(2, "R2 blocked pulse");
    loadBit = 1'b1; run(2, "R2 blocked pulse");
    loadBit = 1'b0; run(8, "R2 blocked pulse");
    loadPin = 1'b0; run(8, "R2 release");

    // R4: second edge inside lockout is dropped
    fcwIn = 32'h0000_0010; loadPin = 1'b1; tick("R4 first");
    loadPin = 1'b0; tick("R4 gap");
    loadPin = 1'b1; tick("R4 inside");
    loadPin = 1'b0; run(4, "R4 window");
    fcwIn = 32'h0000_0999; run(10, "R4 no reload");

    // R4: boundary, next E0 five edges later is accepted
    fcwIn = 32'h0000_0020; loadBit = 1'b1; tick("R4 base");
    loadBit = 1'b0; run(4, "R4 base gap");
    loadBit = 1'b1; tick("R4 boundary E0");
    loadBit = 1'b0; run(4, "R4 boundary");
    fcwIn = 32'h0000_0040; run(8, "R4 boundary run");

    // R5: correction sign
    loopVal = 16'hFFFB; addLoop = 1'b1; run(4, "R5 add neg");
    addLoop = 1'b0; run(4, "R5 sub neg");
    loopVal = 16'h7FFF; run(4, "R5 sub pos");
    addLoop = 1'b1; run(4, "R5 add pos");
    loopVal = 16'h0000;

    // R6: test carry
    carryIn = 1'b1; run(5, "R6 carry on");
    carryIn = 1'b0; run(3, "R6 carry off");

    // R7: disable cancels pending load and clears word
    fcwIn = 32'h0001_0000; loadPin = 1'b1; run(3, "R7 pending");
    enable = 1'b0; run(2, "R7 off");
    loadPin = 1'b0; run(4, "R7 off hold");
    enable = 1'b1; run(8, "R7 reenable");
    loopVal = 16'h0003; carryIn = 1'b1; run(4, "R7 loop only");
    loopVal = 16'h0000; carryIn = 1'b0;

    // R8: wrap
    fcwIn = 32'hF000_0000; loadBit = 1'b1; tick("R8 load");
    loadBit = 1'b0; run(20, "R8 wrap");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule